// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block derives the clocks of an audio serial port from a fast system clock `clk`. Three slower reference waveforms arrive as levels: two internal sources and one external reference. Each is re-sampled in the `clk` domain. In fractional mode, a phase accumulator on the selected source produces a master clock at `f_src * M / N`. In bypass mode, the external reference drives the master clock directly.

An integer divider turns the master clock into a bit clock. Its programmed value is the ratio minus one. Every master-clock edge, rising or falling, advances the divider, so the bit clock runs at one period per `bdiv + 1` master periods. A frame-sync output toggles once per 32 bit clocks.

Software chooses M, N and the divider value. It stops the bit clock with `bclk_stop`, changes the settings, and releases the stop. The settings are captured only while the bit clock is parked low. A restart therefore always begins with a full low phase. All outputs are registered in the `clk` domain. The reference inputs must toggle no faster than once every two `clk` cycles.

Top module: `audclk_gen`

## Requirements
- R1: In fractional mode, the accumulator adds 2·M on every rising edge of the selected source and wraps at N. Each wrap toggles `mclk_o`, so the master frequency is `f_src·M/N`.
- R2: `src_sel` = 0 selects `src_a` as the fractional source, and `src_sel` = 1 selects `src_b`.
- R3: An M/N pair is illegal when M = 0, N = 0, M > 512, N > 8192 or N < 2·M. With an illegal pair in fractional mode, `mclk_o` stays low.
- R4: The fractional path is used only when `frac_en` = 1 and `frac_mode` = 1. If either is 0, `mclk_o` follows `ext_ref` edge for edge, with a fixed delay of a few `clk` cycles.
- R5: While `mclk_en` = 0, `mclk_o` is held low, produces no edges, and the bit clock does not advance.
- R6: Each high phase and each low phase of `bclk_o` spans `bdiv + 1` master-clock edges. A `bdiv` value above 511 acts as 511.
- R7: When `bclk_stop` is asserted, any high phase in progress runs to its full length. `bclk_o` then stays low until the stop is released. No high phase is ever shortened.
- R8: M, N, `src_sel`, `frac_en`, `frac_mode` and `bdiv` are captured during reset and while the bit clock is parked (`bclk_stop` = 1 and `bclk_o` low). Changes at other times have no effect.
- R9: `fsync_o` toggles on every 32nd falling edge of `bclk_o`. Each frame-sync phase therefore spans 32 bit clocks. While the bit clock is parked, `fsync_o` and its count return to zero.
- R10: During reset and in the cycle after it, `mclk_o`, `bclk_o` and `fsync_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the references and run all logic |
| rst | input | 1 | Synchronous active-high reset; also captures the settings |
| src_a | input | 1 | Internal source 0 (level) |
| src_b | input | 1 | Internal source 1 (level) |
| ext_ref | input | 1 | External reference used in bypass mode (level) |
| src_sel | input | 1 | Fractional source: 0 = src_a, 1 = src_b |
| frac_en | input | 1 | Fractional divider enable |
| frac_mode | input | 1 | Fractional path mode; both this and frac_en must be 1 |
| mclk_en | input | 1 | Master-clock output enable |
| m_val | input | 10 | Numerator M |
| n_val | input | 14 | Denominator N |
| bdiv | input | 10 | Bit-clock ratio minus one (capped at 511) |
| bclk_stop | input | 1 | Parks the bit clock low after the current high phase |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync, 32 bit clocks per phase |

## Verification
The fractional rate is tested with each source and with M/N pairs chosen at random under the legality rules. It is also tested at the 1/2 and 1/16 extremes. The rate is judged against the source edges counted in the same window, which exposes errors in accumulator step, wrap point and source selection. Each class of illegal pair and both bypass encodings are checked against an edge count of zero or of the external reference.

The bit-clock structure is checked by counting master edges inside every high phase. This is done in both modes, at the clamped maximum, and across a stop and restart, so that a short or runt phase shows up as a count mismatch. Changes to M and to `bdiv` are applied while the clock runs, to confirm they are deferred until the next parked period.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    // Path settings held together so they are captured as one word.
    typedef struct packed {
        logic use_b;
        logic frac_en;
        logic frac_mode;
    } path_cfg_t;

    typedef enum logic {
        PATH_BYPASS = 1'b0,
        PATH_FRAC   = 1'b1
    } master_path_e;

    localparam int unsigned FRAME_HALF_DEFAULT = 32;

    function automatic master_path_e path_of(input path_cfg_t c);
        return (c.frac_en && c.frac_mode) ? PATH_FRAC : PATH_BYPASS;
    endfunction

endpackage

// File: rtl/audclk_level_sampler.sv
module audclk_level_sampler (
    input  logic clk,
    input  logic rst,
    input  logic in_i,
    output logic lvl_o
);
    logic [1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[0], in_i};
    end

    assign lvl_o = sh_q[1];
endmodule

// File: rtl/audclk_mn_div.sv
module audclk_mn_div
    import audclk_pkg::*;
#(
    parameter  int unsigned M_MAX = 512,
    parameter  int unsigned N_MAX = 8192,
    localparam int unsigned MW    = $clog2(M_MAX + 1),
    localparam int unsigned NW    = $clog2(N_MAX + 1),
    localparam int unsigned AW    = NW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [MW-1:0] m_i,
    input  logic [NW-1:0] n_i,
    input  path_cfg_t     cfg_i,
    input  logic          mclk_en_i,
    input  logic [1:0]    src_lvl_i,
    input  logic          ext_lvl_i,
    output logic          mclk_o,
    output logic          edge_o
);
    logic [MW-1:0] m_q;
    logic [NW-1:0] n_q;
    path_cfg_t     cfg_q;
    logic [AW-1:0] acc_q;
    logic          prev_q;
    logic          mclk_q;
    logic          edge_q;

    function automatic logic mn_legal(input logic [MW-1:0] m, input logic [NW-1:0] n);
        return (m != '0) && (n != '0) && (32'(m) <= M_MAX) && (32'(n) <= N_MAX)
            && (AW'(n) >= AW'({m, 1'b0}));
    endfunction

    logic          sel_lvl_w;
    logic          tick_w;
    logic          legal_w;
    logic          changed_w;
    logic [AW-1:0] sum_w;
    master_path_e  path_w;

    assign sel_lvl_w = cfg_q.use_b ? src_lvl_i[1] : src_lvl_i[0];
    assign tick_w    = sel_lvl_w & ~prev_q;
    assign legal_w   = mn_legal(m_q, n_q);
    assign path_w    = path_of(cfg_q);
    assign sum_w     = acc_q + AW'({m_q, 1'b0});
    assign changed_w = (m_i != m_q) || (n_i != n_q) || (cfg_i != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q    <= m_i;
            n_q    <= n_i;
            cfg_q  <= cfg_i;
            acc_q  <= '0;
            prev_q <= 1'b0;
            mclk_q <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            edge_q <= 1'b0;
            prev_q <= sel_lvl_w;
            if (!mclk_en_i) begin
                mclk_q <= 1'b0;
            end else if (path_w == PATH_FRAC) begin
                if (!legal_w) begin
                    mclk_q <= 1'b0;
                end else if (tick_w) begin
                    if (sum_w >= AW'(n_q)) begin
                        acc_q  <= sum_w - AW'(n_q);
                        mclk_q <= ~mclk_q;
                        edge_q <= 1'b1;
                    end else begin
                        acc_q <= sum_w;
                    end
                end
            end else if (ext_lvl_i != mclk_q) begin
                mclk_q <= ext_lvl_i;
                edge_q <= 1'b1;
            end
            if (load_i) begin
                m_q   <= m_i;
                n_q   <= n_i;
                cfg_q <= cfg_i;
                if (changed_w) acc_q <= '0;
            end
        end
    end

    assign mclk_o = mclk_q;
    assign edge_o = edge_q;

    // R1: phase stays inside one modulus period
    p_acc_below_n_r1: assert property (@(posedge clk) disable iff (rst)
        (path_w == PATH_FRAC && legal_w) |-> (acc_q < AW'(n_q)));

    // R1: an edge strobe always accompanies a real master-clock change
    p_strobe_is_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        edge_q |-> (mclk_q != $past(mclk_q)));

    // R3: illegal ratio silences the fractional output
    p_illegal_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (path_w == PATH_FRAC && !legal_w) |=> !mclk_q);

    // R5: disabled master clock is low and quiet
    p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
        !mclk_en_i |=> (!mclk_q && !edge_q));
endmodule

// File: rtl/audclk_bit_div.sv
module audclk_bit_div #(
    parameter  int unsigned DIV_MAX    = 512,
    parameter  int unsigned FRAME_BITS = 32,
    localparam int unsigned DW         = $clog2(DIV_MAX) + 1,
    localparam int unsigned FCW        = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stop_i,
    input  logic [DW-1:0] div_i,
    input  logic          edge_i,
    output logic          bclk_o,
    output logic          fsync_o,
    output logic          idle_o
);
    logic [DW-1:0]  div_q;
    logic [DW-1:0]  cnt_q;
    logic [FCW-1:0] fcnt_q;
    logic           bclk_q;
    logic           fsync_q;

    logic [DW-1:0]  capped_w;
    logic           idle_w;

    assign capped_w = (32'(div_i) > DIV_MAX - 1) ? DW'(DIV_MAX - 1) : div_i;
    assign idle_w   = !bclk_q && stop_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= capped_w;
            cnt_q   <= '0;
            fcnt_q  <= '0;
            bclk_q  <= 1'b0;
            fsync_q <= 1'b0;
        end else if (idle_w) begin
            div_q   <= capped_w;
            cnt_q   <= '0;
            fcnt_q  <= '0;
            fsync_q <= 1'b0;
        end else if (edge_i) begin
            if (cnt_q == div_q) begin
                cnt_q <= '0;
                if (bclk_q) begin
                    bclk_q <= 1'b0;
                    if (fcnt_q == FCW'(FRAME_BITS - 1)) begin
                        fcnt_q  <= '0;
                        fsync_q <= ~fsync_q;
                    end else begin
                        fcnt_q <= fcnt_q + 1'b1;
                    end
                end else begin
                    bclk_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign bclk_o  = bclk_q;
    assign fsync_o = fsync_q;
    assign idle_o  = idle_w;

    // R7: a parked bit clock stays low
    p_park_low_r7: assert property (@(posedge clk) disable iff (rst)
        (!bclk_q && stop_i) |=> !bclk_q);

    // R6: the bit clock moves only on a master-clock edge
    p_move_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
        !edge_i |=> $stable(bclk_q));

    // R6: edge counter never passes the stored ratio
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= div_q);

    // R8: stored ratio frozen while running
    p_div_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !idle_w |=> $stable(div_q));

    // R9: frame sync changes only with a bit-clock fall or a park
    p_fsync_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsync_q) |-> ($fell(bclk_q) || $past(idle_w)));
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
    import audclk_pkg::*;
#(
    parameter  int unsigned M_MAX      = 512,
    parameter  int unsigned N_MAX      = 8192,
    parameter  int unsigned DIV_MAX    = 512,
    parameter  int unsigned FRAME_BITS = FRAME_HALF_DEFAULT,
    localparam int unsigned MW         = $clog2(M_MAX + 1),
    localparam int unsigned NW         = $clog2(N_MAX + 1),
    localparam int unsigned DW         = $clog2(DIV_MAX) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          src_a,
    input  logic          src_b,
    input  logic          ext_ref,
    input  logic          src_sel,
    input  logic          frac_en,
    input  logic          frac_mode,
    input  logic          mclk_en,
    input  logic [MW-1:0] m_val,
    input  logic [NW-1:0] n_val,
    input  logic [DW-1:0] bdiv,
    input  logic          bclk_stop,
    output logic          mclk_o,
    output logic          bclk_o,
    output logic          fsync_o
);
    localparam int NREF = 3;

    logic [NREF-1:0] raw_w;
    logic [NREF-1:0] lvl_w;
    path_cfg_t       cfg_w;
    logic            idle_w;
    logic            medge_w;

    assign raw_w = {ext_ref, src_b, src_a};
    assign cfg_w = '{use_b: src_sel, frac_en: frac_en, frac_mode: frac_mode};

    for (genvar i = 0; i < NREF; i++) begin : g_ref
        audclk_level_sampler u_smp (
            .clk   (clk),
            .rst   (rst),
            .in_i  (raw_w[i]),
            .lvl_o (lvl_w[i])
        );
    end

    audclk_mn_div #(.M_MAX(M_MAX), .N_MAX(N_MAX)) u_mn (
        .clk       (clk),
        .rst       (rst),
        .load_i    (idle_w),
        .m_i       (m_val),
        .n_i       (n_val),
        .cfg_i     (cfg_w),
        .mclk_en_i (mclk_en),
        .src_lvl_i (lvl_w[1:0]),
        .ext_lvl_i (lvl_w[2]),
        .mclk_o    (mclk_o),
        .edge_o    (medge_w)
    );

    audclk_bit_div #(.DIV_MAX(DIV_MAX), .FRAME_BITS(FRAME_BITS)) u_bit (
        .clk     (clk),
        .rst     (rst),
        .stop_i  (bclk_stop),
        .div_i   (bdiv),
        .edge_i  (medge_w),
        .bclk_o  (bclk_o),
        .fsync_o (fsync_o),
        .idle_o  (idle_w)
    );

    // R10: outputs low right after a reset cycle
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!mclk_o && !bclk_o && !fsync_o));
endmodule

// File: tb/audclk_gen_bench.sv
`timescale 1ns/100ps
module audclk_gen_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic src_a = 1'b0, src_b = 1'b0, ext_ref = 1'b0;
    logic src_sel = 1'b0, frac_en = 1'b1, frac_mode = 1'b1, mclk_en = 1'b1;
    logic [9:0]  m_val = 10'd3;
    logic [13:0] n_val = 14'd16;
    logic [9:0]  bdiv = 10'd1;
    logic bclk_stop = 1'b0;
    logic mclk_o, bclk_o, fsync_o;

    initial begin #1.3; forever #20 src_a = ~src_a; end
    initial begin #1.3; forever #30 src_b = ~src_b; end
    initial begin #1.7; forever #25 ext_ref = ~ext_ref; end

    audclk_gen u_audclk_gen (
        .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .ext_ref(ext_ref),
        .src_sel(src_sel), .frac_en(frac_en), .frac_mode(frac_mode), .mclk_en(mclk_en),
        .m_val(m_val), .n_val(n_val), .bdiv(bdiv), .bclk_stop(bclk_stop),
        .mclk_o(mclk_o), .bclk_o(bclk_o), .fsync_o(fsync_o)
    );

    int n_chk = 0, n_fail = 0;
    int ar, br, er, mr, bcr, e_cnt, hmin, hmax, hn, fb, fmin, fmax, fn;
    bit hv, fv;
    logic pa = 0, pbs = 0, pe = 0, pm = 0, pb = 0, pf = 0;

    always @(negedge clk) begin
        if (src_a && !pa) ar++;
        if (src_b && !pbs) br++;
        if (ext_ref && !pe) er++;
        if (mclk_o && !pm) mr++;
        if (bclk_o && !pb) begin bcr++; fb++; e_cnt = 0; hv = 1; end
        if (!bclk_o && pb && hv) begin
            hn++;
            if (e_cnt < hmin) hmin = e_cnt;
            if (e_cnt > hmax) hmax = e_cnt;
        end
        if ((mclk_o != pm) && bclk_o) e_cnt++;
        if (fsync_o != pf) begin
            if (fv) begin
                fn++;
                if (fb < fmin) fmin = fb;
                if (fb > fmax) fmax = fb;
            end
            fv = 1; fb = 0;
        end
        if (bclk_stop) fv = 0;
        pa = src_a; pbs = src_b; pe = ext_ref; pm = mclk_o; pb = bclk_o; pf = fsync_o;
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_stats();
        ar = 0; br = 0; er = 0; mr = 0; bcr = 0; e_cnt = 0;
        hmin = 1000000; hmax = 0; hn = 0; hv = 0;
        fb = 0; fmin = 1000000; fmax = 0; fn = 0; fv = 0;
    endtask

    task automatic window(input int n);
        @(posedge clk);
        clear_stats();
        cyc(n);
    endtask

    task automatic reconfig(input int m, input int n, input bit sel, input bit fe,
                            input bit fm, input int bd);
        bclk_stop = 1'b1;
        for (int i = 0; i < 40000 && bclk_o; i++) @(negedge clk);
        cyc(4);
        m_val = m[9:0]; n_val = n[13:0]; src_sel = sel;
        frac_en = fe; frac_mode = fm; bdiv = bd[9:0];
        cyc(4);
        bclk_stop = 1'b0;
        cyc(60);
    endtask

    function automatic int exp_rises(input int srcr, input int m, input int n);
        return (srcr * m) / n;
    endfunction

    function automatic bit near(input int a, input int b, input int tol);
        return (a - b <= tol) && (b - a <= tol);
    endfunction

    task automatic frac_rate(input string req, input int m, input int n, input bit sel);
        int srcr, ex;
        window(4000);
        srcr = sel ? br : ar;
        ex = exp_rises(srcr, m, n);
        chk(req, near(mr, ex, 2), mr, ex);
    endtask

    initial begin
        clear_stats();
        void'($urandom(32'd20240517));
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 mclk in reset", mclk_o == 1'b0, mclk_o, 0);
        chk("R10 bclk in reset", bclk_o == 1'b0, bclk_o, 0);
        chk("R10 fsync in reset", fsync_o == 1'b0, fsync_o, 0);
        cyc(8);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 outputs after reset", {mclk_o, bclk_o, fsync_o} == 3'b000,
            {mclk_o, bclk_o, fsync_o}, 0);

        // R1 / R6 fractional rate and phase structure
        reconfig(3, 16, 1'b0, 1'b1, 1'b1, 1);
        frac_rate("R1 src_a 3/16", 3, 16, 1'b0);
        chk("R6 frac high phase min", hn > 0 && hmin == 2, hmin, 2);
        chk("R6 frac high phase max", hmax == 2, hmax, 2);

        // R2 source select
        reconfig(3, 16, 1'b1, 1'b1, 1'b1, 1);
        frac_rate("R2 src_b 3/16", 3, 16, 1'b1);

        // R1 random legal ratios
        for (int k = 0; k < 6; k++) begin
            int m, n;
            bit s;
            m = 1 + int'($urandom % 300);
            n = 2 * m + int'($urandom % (6 * m + 1));
            s = 1'($urandom % 2);
            reconfig(m, n, s, 1'b1, 1'b1, 1);
            frac_rate("R1 random ratio", m, n, s);
        end

        // R1 extremes
        reconfig(512, 8192, 1'b0, 1'b1, 1'b1, 1);
        frac_rate("R1 512/8192", 512, 8192, 1'b0);
        reconfig(1, 2, 1'b0, 1'b1, 1'b1, 1);
        frac_rate("R1 1/2", 1, 2, 1'b0);

        // R3 illegal pairs
        reconfig(0, 16, 1'b0, 1'b1, 1'b1, 1);
        window(1500); chk("R3 M zero", mr == 0, mr, 0);
        reconfig(4, 0, 1'b0, 1'b1, 1'b1, 1);
        window(1500); chk("R3 N zero", mr == 0, mr, 0);
        reconfig(513, 8192, 1'b0, 1'b1, 1'b1, 1);
        window(1500); chk("R3 M too large", mr == 0, mr, 0);
        reconfig(10, 8200, 1'b0, 1'b1, 1'b1, 1);
        window(1500); chk("R3 N too large", mr == 0, mr, 0);
        reconfig(300, 599, 1'b1, 1'b1, 1'b1, 1);
        window(1500); chk("R3 N below 2M", mr == 0, mr, 0);
        @(negedge clk); chk("R3 mclk low", mclk_o == 1'b0, mclk_o, 0);

        // R4 bypass encodings
        reconfig(3, 16, 1'b0, 1'b1, 1'b0, 1);
        window(3000); chk("R4 bypass mode=0", near(mr, er, 1), mr, er);
        reconfig(3, 16, 1'b0, 1'b0, 1'b1, 1);
        window(3000); chk("R4 bypass en=0", near(mr, er, 1), mr, er);

        // R9 frame sync in bypass, ratio 2
        window(4000);
        chk("R9 frames seen", fn >= 2, fn, 2);
        chk("R9 min bits per phase", fmin == 32, fmin, 32);
        chk("R9 max bits per phase", fmax == 32, fmax, 32);

        // R5 master enable
        mclk_en = 1'b0;
        cyc(20);
        window(2000);
        chk("R5 no mclk edges", mr == 0, mr, 0);
        chk("R5 bclk stalled", bcr == 0, bcr, 0);
        @(negedge clk); chk("R5 mclk low", mclk_o == 1'b0, mclk_o, 0);
        mclk_en = 1'b1;
        cyc(50);
        window(2000);
        chk("R5 mclk resumes", near(mr, er, 1), mr, er);

        // R6 ratio 4 and clamp
        reconfig(3, 16, 1'b0, 1'b0, 1'b0, 3);
        window(3000);
        chk("R6 ratio 4 phases", hn > 0 && hmin == 4 && hmax == 4, hmax, 4);
        reconfig(3, 16, 1'b0, 1'b0, 1'b0, 1023);
        window(8000);
        chk("R6 clamped ratio", hn > 0 && hmin == 512 && hmax == 512, hmin, 512);

        // R7 stop and restart
        reconfig(3, 16, 1'b0, 1'b0, 1'b0, 3);
        window(300 + int'($urandom % 13));
        bclk_stop = 1'b1;
        cyc(400);
        @(negedge clk); chk("R7 parked low", bclk_o == 1'b0, bclk_o, 0);
        begin
            int held;
            held = bcr;
            cyc(300);
            chk("R7 no pulses while stopped", bcr == held, bcr, held);
        end
        bclk_stop = 1'b0;
        cyc(600);
        chk("R7 full phases across stop", hn > 0 && hmin == 4 && hmax == 4, hmin, 4);

        // R8 live changes ignored until parked
        reconfig(3, 16, 1'b0, 1'b1, 1'b1, 1);
        m_val = 10'd6;
        bdiv = 10'd5;
        cyc(20);
        frac_rate("R8 live M ignored", 3, 16, 1'b0);
        chk("R8 live bdiv ignored", hn > 0 && hmin == 2 && hmax == 2, hmax, 2);
        reconfig(6, 16, 1'b0, 1'b1, 1'b1, 5);
        frac_rate("R8 M taken when parked", 6, 16, 1'b0);
        chk("R8 bdiv taken when parked", hn > 0 && hmin == 6 && hmax == 6, hmax, 6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule